// File: doc/BRIEF.md
# Sub-Clock Fixed-Interval Timer

This block produces a periodic interrupt request from a slow sub-clock. The counting rate is given by `sub_tick`, a one-cycle enable pulse for each period of the 32.768 kHz sub-clock. The pulse is synchronised into the system clock domain before it reaches this block.

There is no reload value. A 2-bit select code picks the interval, and each choice is a power-of-two number of sub-clock periods. The counter is a free-running binary counter. An interval completes when the carry leaves the selected bit position. On that event the request flag is set and counting goes on without a break.

Software controls the block through a 4-bit control write:

- Bit 2 runs the timer when 1 and stops it when 0.
- Bits 1:0 hold the select code.
- Bit 3 is a spare bit with no function.

Writing the stop state clears the count. To change the interval, software stops the timer, writes the new code and then restarts it. Software reads the flag and clears it with a test-and-clear strobe. The interrupt line is the flag gated by a local enable and a global enable.

Top module: `subclk_interval_timer`

## Requirements
- R1: After reset the count is 0, the flag is 0, `irq_o` is 0 and the timer is stopped.
- R2: While the timer runs, the count rises by one for each cycle with `sub_tick` high and holds on cycles with `sub_tick` low.
- R3: A control write with bit 2 = 0 sets the count to 0 on the next cycle. While the timer is stopped, `sub_tick` pulses change neither the count nor the flag.
- R4: With select code 01 (bits 1:0), starting from a cleared count, the flag stays 0 after 2^14 - 1 ticks and is 1 after 2^14 ticks.
- R5: Select codes 00, 10 and 11 give intervals of 2^12, 2^15 and 2^16 ticks.
- R6: After an interval completes the timer keeps counting, and the flag is set again one full interval later. With code 11 the count wraps to 0 when the interval completes.
- R7: A cycle with `flag_test` high clears the flag on the next cycle. If an interval completes in that same cycle, the flag is set instead of cleared.
- R8: `irq_o` equals flag AND `tmr_irq_en` AND `glob_irq_en`.
- R9: Bit 3 of the control write has no effect on counting or on the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sub_tick | input | 1 | One-cycle pulse per sub-clock period (count enable) |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | Control write data: bit 2 runs the timer, bits 1:0 select the interval, bit 3 is a spare |
| flag_test | input | 1 | Test-and-clear strobe for the request flag |
| tmr_irq_en | input | 1 | Local interrupt enable for this timer |
| glob_irq_en | input | 1 | Global interrupt enable |
| count_o | output | CNT_W | Current count value |
| flag_o | output | 1 | Interval request flag |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The main path is exercised with every select code, driving tick counts that stop one short of the interval and tick counts that reach it exactly. This distinguishes an off-by-one in the tap compare and any confusion between codes. The 2^16 case also shows that the counter wraps.

A continued run after the flag is cleared separates true free-running behaviour from a design that reloads or stops. A stop issued mid-count followed by idle ticks confirms the clear and the gating. A clear strobe that lands on the completing tick fixes the set-over-clear priority. Gaps in the tick stream separate counting ticks from counting clock cycles.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int unsigned NSEL  = 4;
  localparam int unsigned SEL_W = $clog2(NSEL);

  typedef struct packed {
    logic             run;
    logic [SEL_W-1:0] sel;
  } sct_cfg_t;

  function automatic logic [31:0] tap_mask(input int unsigned tap);
    return (32'd1 << tap) - 32'd1;
  endfunction
endpackage

// File: rtl/sct_ctrl.sv
module sct_ctrl
  import sct_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [3:0]     wdata,
  output sct_cfg_t       cfg,
  output logic           clr
);
  logic spare_unused;
  assign spare_unused = wdata[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr) begin
      cfg.run <= wdata[2];
      cfg.sel <= wdata[SEL_W-1:0];
    end
  end

  assign clr = wr && !wdata[2];
endmodule

// File: rtl/sct_counter.sv
module sct_counter
  import sct_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TAP0  = 12,
  parameter int unsigned TAP1  = 14,
  parameter int unsigned TAP2  = 15,
  parameter int unsigned TAP3  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sct_cfg_t         cfg,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             evt
);
  logic [CNT_W-1:0] mask [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_tap
    localparam int unsigned TV = (g == 0) ? TAP0 : (g == 1) ? TAP1 :
                                 (g == 2) ? TAP2 : TAP3;
    localparam logic [31:0] M = tap_mask(TV);
    assign mask[g] = M[CNT_W-1:0];
  end

  logic step;
  assign step = cfg.run && tick;
  assign evt  = step && ((cnt & mask[cfg.sel]) == mask[cfg.sel]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end

  // R3
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt));
  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/sct_flag.sv
module sct_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic test,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (evt)  flag <= 1'b1;
    else if (test) flag <= 1'b0;
  end

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);
  // R7
  test_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test && !evt) |=> !flag);
endmodule

// File: rtl/subclk_interval_timer.sv
module subclk_interval_timer
  import sct_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TAP0  = 12,
  parameter int unsigned TAP1  = 14,
  parameter int unsigned TAP2  = 15,
  parameter int unsigned TAP3  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sub_tick,
  input  logic             ctrl_wr,
  input  logic [3:0]       ctrl_wdata,
  input  logic             flag_test,
  input  logic             tmr_irq_en,
  input  logic             glob_irq_en,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o,
  output logic             irq_o
);
  sct_cfg_t cfg;
  logic     clr;
  logic     evt;

  sct_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ctrl_wr),
    .wdata (ctrl_wdata),
    .cfg   (cfg),
    .clr   (clr)
  );

  sct_counter #(
    .CNT_W (CNT_W), .TAP0 (TAP0), .TAP1 (TAP1), .TAP2 (TAP2), .TAP3 (TAP3)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cfg   (cfg),
    .clr   (clr),
    .tick  (sub_tick),
    .cnt   (count_o),
    .evt   (evt)
  );

  sct_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt),
    .test  (flag_test),
    .flag  (flag_o)
  );

  assign irq_o = flag_o && tmr_irq_en && glob_irq_en;

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_o && tmr_irq_en && glob_irq_en));
  // R3
  stopped_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.run && !flag_o) |=> !flag_o);
endmodule

// File: tb/subclk_interval_timer_test.sv
module subclk_interval_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sub_tick = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [3:0]  ctrl_wdata = '0;
  logic        flag_test = 1'b0;
  logic        tmr_irq_en = 1'b0;
  logic        glob_irq_en = 1'b0;
  logic [15:0] count_o;
  logic        flag_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  subclk_interval_timer uut (
    .clk (clk), .rst_n (rst_n), .sub_tick (sub_tick), .ctrl_wr (ctrl_wr),
    .ctrl_wdata (ctrl_wdata), .flag_test (flag_test), .tmr_irq_en (tmr_irq_en),
    .glob_irq_en (glob_irq_en), .count_o (count_o), .flag_o (flag_o), .irq_o (irq_o)
  );

  typedef struct packed {
    logic [3:0]  ctrl;
    logic [16:0] n;
    logic        fl;
    logic [15:0] cnt;
  } vec_t;

  // bits 1:0 select, bit 2 run, bit 3 spare
  localparam vec_t VECS [4] = '{
    '{4'b0100, 17'd4095,  1'b0, 16'd4095},   // R5 code 00 one short
    '{4'b1100, 17'd4096,  1'b1, 16'd4096},   // R5 R9 code 00 exact, spare set
    '{4'b0110, 17'd32768, 1'b1, 16'd32768},  // R5 code 10
    '{4'b0111, 17'd65536, 1'b1, 16'd0}       // R5 R6 code 11 with wrap
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [3:0] v);
    ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    sub_tick = 1'b1;
    repeat (n) @(negedge clk);
    sub_tick = 1'b0;
  endtask

  task automatic test_flag();
    flag_test = 1'b1;
    @(negedge clk);
    flag_test = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected <190000 cycles", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 flag", flag_o, 0);
    chk("R1 irq", irq_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 ticks ignored while stopped after reset
    ticks(20);
    chk("R3 stopped count", count_o, 0);
    chk("R3 stopped flag", flag_o, 0);

    for (int i = 0; i < 4; i++) begin
      test_flag();
      wr_ctrl(4'b0000);
      wr_ctrl(VECS[i].ctrl);
      ticks(int'(VECS[i].n));
      chk("R5 table flag", flag_o, VECS[i].fl);
      chk("R5 table count", count_o, VECS[i].cnt);
    end

    // R4 code 01 boundary
    test_flag();
    wr_ctrl(4'b0000);
    wr_ctrl(4'b0101);
    ticks(16383);
    chk("R4 flag short", flag_o, 0);
    ticks(1);
    chk("R4 flag exact", flag_o, 1);

    // R6 restart after completion
    test_flag();
    wr_ctrl(4'b0000);
    wr_ctrl(4'b0100);
    ticks(4096);
    chk("R6 first set", flag_o, 1);
    test_flag();
    chk("R7 cleared", flag_o, 0);
    ticks(4095);
    chk("R6 count continues", count_o, 8191);
    chk("R6 no early set", flag_o, 0);
    ticks(1);
    chk("R6 second set", flag_o, 1);

    // R8 gating
    tmr_irq_en = 1'b0; glob_irq_en = 1'b1; #1;
    chk("R8 local off", irq_o, 0);
    tmr_irq_en = 1'b1; glob_irq_en = 1'b0; #1;
    chk("R8 global off", irq_o, 0);
    glob_irq_en = 1'b1; #1;
    chk("R8 both on", irq_o, 1);
    @(negedge clk);

    // R7 set wins over simultaneous clear
    test_flag();
    ticks(4095);
    chk("R7 pre flag", flag_o, 0);
    sub_tick = 1'b1; flag_test = 1'b1;
    @(negedge clk);
    sub_tick = 1'b0; flag_test = 1'b0;
    chk("R7 set wins", flag_o, 1);
    test_flag();
    chk("R7 clear alone", flag_o, 0);

    // R3 stop mid-count clears, then idle ticks do nothing
    ticks(7);
    wr_ctrl(4'b0000);
    chk("R3 stop clears", count_o, 0);
    ticks(10);
    chk("R3 idle count", count_o, 0);

    // R2 gapped ticks
    wr_ctrl(4'b0100);
    for (int k = 0; k < 5; k++) begin
      ticks(1);
      repeat (2) @(negedge clk);
    end
    chk("R2 gapped count", count_o, 5);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule